// File: doc/BRIEF.md
# Chained Up-Counter Pair with Hardware Trigger Start

This block holds two up-counting timers that share one clock divider. The first timer (the master) can send a signal on an internal trigger line. A selector field chooses what that line carries: the master's overflow pulse, its run state, or nothing. The second timer (the slave) chooses its trigger source with a field of its own. When the slave is in trigger mode, a rising edge on the chosen line switches the slave on in hardware, so software does not have to start it. The slave then counts on from whatever value its counter already holds. It keeps running until software turns it off. Each trigger also raises a sticky flag, which software clears.

A flat register file is used for control. Each register is written with a one-clock write strobe, address and data, and read back through a combinational read port. A typical use is to load both reload values, put the slave in trigger mode, and start the master. The slave then starts exactly one clock after the first master overflow, without any software action.

The master enable logic is a two-state machine. Its states are `MST_STOP` and `MST_RUN`. A control write with bit 0 set moves it from `MST_STOP` to `MST_RUN`, and a control write with bit 0 clear moves it back.

The slave has a three-state machine:
- `SLV_STOP`: disabled, and not in trigger mode.
- `SLV_ARMED`: disabled, but in trigger mode and waiting for a trigger.
- `SLV_RUN`: counting.

A slave control write moves the machine to one of these states:
- `SLV_RUN` if the enable bit is set.
- `SLV_ARMED` if the enable bit is clear and the mode is trigger mode.
- `SLV_STOP` otherwise.

A qualified trigger edge moves `SLV_ARMED` to `SLV_RUN`. The same edge keeps `SLV_RUN` in `SLV_RUN`, even if a control write arrives in that same clock.

Top module: `tmr_chain`

## Requirements
- R1: After reset, all eight registers read 0, both counters are stopped, and the trigger output and the trigger flag are low.
- R2: The prescaler register (address 7) holds a value P. The divider runs freely from reset and produces a tick every P+1 clocks. An enabled counter advances only on a tick, so it counts once every P+1 clocks. A trigger never restarts the divider.
- R3: Each counter counts up to its reload value (master at address 1, slave at address 4), then wraps to 0 on the next tick. Each wrap makes a one-clock update pulse, and this pulse is high during the clock in which the counter reads 0. With reload R and prescaler P, the master's pulse repeats every (R+1)(P+1) clocks.
- R4: The master control register (address 0) has enable in bit 0 and an output-select field in bits 3:1. Value 010 puts the master update pulse on the trigger output. Value 001 puts the master run state on it. Any other value holds the output low.
- R5: The slave control register (address 3) has a trigger-source field in bits 8:4. Only value 00010 connects the master's trigger output to the slave. Any other value means the slave sees no trigger.
- R6: The slave control register has a mode field in bits 3:1, and value 110 is trigger mode. In trigger mode, a rising edge on the chosen trigger line sets the slave enable (bit 0). The enable reads 1 in the clock after the clock in which the trigger line is high.
- R7: When a trigger starts the slave, its counter keeps its current value, which may be non-zero. The counter is not reloaded. The first increment comes on the next divider tick.
- R8: Once started, the slave keeps counting until software writes 0 to its enable bit. From then on, its counter holds its value.
- R9: The trigger flag is bit 0 of address 6. A trigger edge in trigger mode sets it. Writing 0 to it clears it, and writing 1 has no effect. If a set and a clear happen in the same clock, the set wins.
- R10: A write to a counter register (address 2 or 5) shows in the next clock. It overrides any increment in that clock and suppresses that clock's update pulse.
- R11: A trigger edge that arrives while the slave is already running sets the flag again. It does not change the slave's count or run state.
- R12: Outside trigger mode, trigger edges neither set the slave enable nor set the flag.
- R13: The reload and prescaler registers read back the value written. The control registers read back only their defined fields, and all other bits read 0. A counter register written while its timer is stopped reads back the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | One-clock register write strobe |
| wr_addr | input | 3 | Register address for the write |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 3 | Register address for the read |
| rd_data | output | CNT_W | Combinational read data |
| mst_trig_out | output | 1 | Master trigger output, as chosen by the output-select field |
| slv_trig_flag | output | 1 | Sticky slave trigger flag |

## Verification
Some rules are checked by assertions on every clock:
- A qualified trigger edge always starts the slave and sets the flag one clock later.
- The slave never changes its count in the clock it is started, unless software wrote the count.
- A stopped slave holds its count.
- A master without a tick holds its count.
- An update pulse always follows a counter at its reload value, and the counter reads 0 while the pulse is high.
- A counter write lands on the next clock.

Other behaviour needs a scenario and is checked only by the bench. This covers the exact divider period, the master's update period, and the count the slave reaches one full master period after its start. It also covers the silence of the trigger line when the source or mode does not match, and the output-select decoding.

// File: rtl/tmr_chain_pkg.sv
package tmr_chain_pkg;

    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        A_MCTRL   = 3'd0,
        A_MRELOAD = 3'd1,
        A_MCOUNT  = 3'd2,
        A_SCTRL   = 3'd3,
        A_SRELOAD = 3'd4,
        A_SCOUNT  = 3'd5,
        A_FLAG    = 3'd6,
        A_PSC     = 3'd7
    } reg_addr_e;

    // master output-select codes
    localparam logic [2:0] OUT_NONE   = 3'b000;
    localparam logic [2:0] OUT_RUN    = 3'b001;
    localparam logic [2:0] OUT_UPDATE = 3'b010;

    // slave mode and trigger source codes
    localparam logic [2:0] MODE_TRIGGER = 3'b110;
    localparam logic [4:0] SRC_MASTER   = 5'b00010;

    typedef enum logic {
        MST_STOP,
        MST_RUN
    } mst_state_e;

    typedef enum logic [1:0] {
        SLV_STOP,
        SLV_ARMED,
        SLV_RUN
    } slv_state_e;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);

    logic [PSC_W-1:0] div_q;

    // free-running divider; a lowered limit ends the current period at once
    assign tick = (div_q >= psc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_upcounter.sv
module tmr_upcounter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             upd
);

    logic [CNT_W-1:0] cnt_q;
    logic             step;
    logic             wrap;

    assign step = run && tick;
    assign wrap = step && (cnt_q >= reload);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            upd   <= 1'b0;
        end else if (load) begin
            cnt_q <= load_val;
            upd   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            upd   <= 1'b1;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
            upd   <= 1'b0;
        end else begin
            upd   <= 1'b0;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/tmr_slave_fsm.sv
module tmr_slave_fsm
    import tmr_chain_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic wr_run,
    input  logic wr_trig_mode,
    input  logic trig_mode,
    input  logic trig_edge,
    output logic run
);

    slv_state_e st_q;
    slv_state_e st_nxt;

    function automatic slv_state_e from_write(input logic en_bit, input logic trig_bit);
        if (en_bit) begin
            return SLV_RUN;
        end else if (trig_bit) begin
            return SLV_ARMED;
        end
        return SLV_STOP;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SLV_STOP;
        end else begin
            st_q <= st_nxt;
        end
    end

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            SLV_STOP: begin
                if (ctrl_wr) begin
                    st_nxt = from_write(wr_run, wr_trig_mode);
                end
            end
            SLV_ARMED: begin
                if (trig_edge) begin
                    st_nxt = SLV_RUN;
                end else if (ctrl_wr) begin
                    st_nxt = from_write(wr_run, wr_trig_mode);
                end
            end
            SLV_RUN: begin
                if (trig_edge && trig_mode) begin
                    st_nxt = SLV_RUN;
                end else if (ctrl_wr) begin
                    st_nxt = from_write(wr_run, wr_trig_mode);
                end
            end
            default: st_nxt = SLV_STOP;
        endcase
    end

    always_comb begin
        run = (st_q == SLV_RUN);
    end

endmodule

// File: rtl/tmr_chain.sv
module tmr_chain
    import tmr_chain_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              mst_trig_out,
    output logic              slv_trig_flag
);

    reg_addr_e        wa;
    logic             m_ctrl_wr;
    logic             m_cnt_wr;
    logic             s_ctrl_wr;
    logic             s_cnt_wr;
    logic             flag_wr;

    logic [2:0]       m_out_sel;
    logic [CNT_W-1:0] m_reload;
    logic [2:0]       s_mode;
    logic [4:0]       s_trig_src;
    logic [CNT_W-1:0] s_reload;
    logic [CNT_W-1:0] psc_q;

    mst_state_e       m_st;
    mst_state_e       m_nxt;
    logic             m_run;
    logic             s_run;
    logic             tick;
    logic [CNT_W-1:0] m_cnt;
    logic [CNT_W-1:0] s_cnt;
    logic             m_upd;
    logic             s_upd;

    logic             trig_line;
    logic             trig_d;
    logic             trig_edge;
    logic             in_trig_mode;
    logic             flag_q;

    assign wa        = reg_addr_e'(wr_addr);
    assign m_ctrl_wr = wr_en && (wa == A_MCTRL);
    assign m_cnt_wr  = wr_en && (wa == A_MCOUNT);
    assign s_ctrl_wr = wr_en && (wa == A_SCTRL);
    assign s_cnt_wr  = wr_en && (wa == A_SCOUNT);
    assign flag_wr   = wr_en && (wa == A_FLAG);

    // setting registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_out_sel  <= OUT_NONE;
            m_reload   <= '0;
            s_mode     <= '0;
            s_trig_src <= '0;
            s_reload   <= '0;
            psc_q      <= '0;
        end else if (wr_en) begin
            unique case (wa)
                A_MCTRL:   m_out_sel <= wr_data[3:1];
                A_MRELOAD: m_reload  <= wr_data;
                A_SCTRL: begin
                    s_mode     <= wr_data[3:1];
                    s_trig_src <= wr_data[8:4];
                end
                A_SRELOAD: s_reload  <= wr_data;
                A_PSC:     psc_q     <= wr_data;
                default: ;
            endcase
        end
    end

    // master enable machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st <= MST_STOP;
        end else begin
            m_st <= m_nxt;
        end
    end

    always_comb begin
        m_nxt = m_st;
        unique case (m_st)
            MST_STOP: if (m_ctrl_wr && wr_data[0])  m_nxt = MST_RUN;
            MST_RUN:  if (m_ctrl_wr && !wr_data[0]) m_nxt = MST_STOP;
        endcase
    end

    always_comb begin
        m_run = (m_st == MST_RUN);
    end

    tmr_prescaler #(.PSC_W(CNT_W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .psc   (psc_q),
        .tick  (tick)
    );

    tmr_upcounter #(.CNT_W(CNT_W)) u_mcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (m_run),
        .tick     (tick),
        .reload   (m_reload),
        .load     (m_cnt_wr),
        .load_val (wr_data),
        .count    (m_cnt),
        .upd      (m_upd)
    );

    tmr_upcounter #(.CNT_W(CNT_W)) u_scnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (s_run),
        .tick     (tick),
        .reload   (s_reload),
        .load     (s_cnt_wr),
        .load_val (wr_data),
        .count    (s_cnt),
        .upd      (s_upd)
    );

    // master trigger output selection
    always_comb begin
        unique case (m_out_sel)
            OUT_UPDATE: mst_trig_out = m_upd;
            OUT_RUN:    mst_trig_out = m_run;
            default:    mst_trig_out = 1'b0;
        endcase
    end

    // slave trigger routing and edge detection
    assign trig_line    = (s_trig_src == SRC_MASTER) ? mst_trig_out : 1'b0;
    assign trig_edge    = trig_line && !trig_d;
    assign in_trig_mode = (s_mode == MODE_TRIGGER);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_d <= 1'b0;
        end else begin
            trig_d <= trig_line;
        end
    end

    tmr_slave_fsm u_sfsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_wr      (s_ctrl_wr),
        .wr_run       (wr_data[0]),
        .wr_trig_mode (wr_data[3:1] == MODE_TRIGGER),
        .trig_mode    (in_trig_mode),
        .trig_edge    (trig_edge),
        .run          (s_run)
    );

    // sticky trigger flag: set beats clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (trig_edge && in_trig_mode) begin
            flag_q <= 1'b1;
        end else if (flag_wr && !wr_data[0]) begin
            flag_q <= 1'b0;
        end
    end

    assign slv_trig_flag = flag_q;

    // read port
    always_comb begin
        rd_data = '0;
        unique case (reg_addr_e'(rd_addr))
            A_MCTRL:   rd_data[3:0] = {m_out_sel, m_run};
            A_MRELOAD: rd_data      = m_reload;
            A_MCOUNT:  rd_data      = m_cnt;
            A_SCTRL:   rd_data[8:0] = {s_trig_src, s_mode, s_run};
            A_SRELOAD: rd_data      = s_reload;
            A_SCOUNT:  rd_data      = s_cnt;
            A_FLAG:    rd_data[0]   = flag_q;
            A_PSC:     rd_data      = psc_q;
        endcase
    end

endmodule

// File: rtl/tmr_chain_sva.sv
module tmr_chain_sva #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             m_run,
    input logic [CNT_W-1:0] m_cnt,
    input logic [CNT_W-1:0] m_reload,
    input logic             m_upd,
    input logic             m_cnt_wr,
    input logic [CNT_W-1:0] wr_data,
    input logic             s_run,
    input logic [CNT_W-1:0] s_cnt,
    input logic             s_upd,
    input logic             s_cnt_wr,
    input logic             s_ctrl_wr,
    input logic [2:0]       s_mode,
    input logic             trig_edge,
    input logic             flag_q
);

    AST_TICK_GATES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !m_cnt_wr) |=> $stable(m_cnt)); // R2

    AST_UPD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        m_upd |-> (m_cnt == '0)); // R3

    AST_UPD_FROM_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        m_upd |-> ($past(m_cnt) >= $past(m_reload))); // R3

    AST_SLV_UPD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        s_upd |-> (s_cnt == '0)); // R3

    AST_TRIG_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_edge && s_mode == 3'b110) |=> s_run); // R6

    AST_START_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(s_run) && !$past(s_cnt_wr)) |-> $stable(s_cnt)); // R7

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_run && !s_cnt_wr) |=> $stable(s_cnt)); // R8

    AST_TRIG_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_edge && s_mode == 3'b110) |=> flag_q); // R9

    AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        m_cnt_wr |=> (m_cnt == $past(wr_data))); // R10

    AST_NO_START_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_run && s_mode != 3'b110 && !s_ctrl_wr) |=> !s_run); // R12

    AST_MASTER_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!m_run && !m_cnt_wr) |=> $stable(m_cnt)); // R8

endmodule

bind tmr_chain tmr_chain_sva #(.CNT_W(CNT_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .m_run     (m_run),
    .m_cnt     (m_cnt),
    .m_reload  (m_reload),
    .m_upd     (m_upd),
    .m_cnt_wr  (m_cnt_wr),
    .wr_data   (wr_data),
    .s_run     (s_run),
    .s_cnt     (s_cnt),
    .s_upd     (s_upd),
    .s_cnt_wr  (s_cnt_wr),
    .s_ctrl_wr (s_ctrl_wr),
    .s_mode    (s_mode),
    .trig_edge (trig_edge),
    .flag_q    (flag_q)
);

// File: tb/tmr_chain_tb.sv
module tmr_chain_tb;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         wr_en;
    logic [2:0]   wr_addr;
    logic [W-1:0] wr_data;
    logic [2:0]   rd_addr;
    logic [W-1:0] rd_data;
    logic         trig_out;
    logic         flag;

    int n_chk = 0;
    int n_bad = 0;
    int ncyc  = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;
    always @(negedge clk) ncyc <= ncyc + 1;

    tmr_chain #(.CNT_W(W)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .rd_addr       (rd_addr),
        .rd_data       (rd_data),
        .mst_trig_out  (trig_out),
        .slv_trig_flag (flag)
    );

    // {address, write data, expected read-back}
    localparam logic [34:0] VEC [0:7] = '{
        {3'd1, 16'h00FF, 16'h00FF},
        {3'd4, 16'h0FFF, 16'h0FFF},
        {3'd7, 16'h0002, 16'h0002},
        {3'd2, 16'h0010, 16'h0010},
        {3'd5, 16'h00AB, 16'h00AB},
        {3'd6, 16'h0001, 16'h0000},
        {3'd0, 16'hFFF4, 16'h0004},
        {3'd3, 16'hFE2C, 16'h002C}
    };

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [W-1:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wait_change(input logic [2:0] a, output int n);
        logic [W-1:0] p;
        logic [W-1:0] v;
        rd(a, p);
        n = 0;
        do begin
            cyc(1);
            n++;
            rd(a, v);
        end while (v == p && n < 50);
    endtask

    task automatic wait_trig(output int at);
        int k = 0;
        do begin
            cyc(1);
            k++;
        end while (!trig_out && k < 100);
        at = ncyc;
    endtask

    task automatic reset_checks(input string tag);
        logic [W-1:0] v;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check(tag, v, '0);
        end
        check(tag, W'(trig_out), '0);
        check(tag, W'(flag), '0);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        int n;
        int t1;
        int t2;
        int highs;

        rst_n   = 1'b0;
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        rd_addr = '0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        reset_checks("R1 reset state");

        // register access table
        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][34:32], VEC[i][31:16]);
            cyc(1);
            rd(VEC[i][34:32], v);
            check("R13 register table", v, VEC[i][15:0]);
        end

        // master reload 5, count 0, prescaler 2; slave armed at 0xAB
        wr(3'd1, 16'd5);
        wr(3'd2, 16'd0);
        wr(3'd0, 16'h0005);

        wait_change(3'd2, n);
        wait_change(3'd2, n);
        check("R2 tick spacing", W'(n), 16'd3);

        wait_trig(t1);
        rd(3'd2, v);
        check("R3 count zero with update", v, 16'd0);
        rd(3'd3, v);
        check("R6 not yet started", v, 16'h002C);
        cyc(1);
        check("R3 one-clock pulse", W'(trig_out), 16'd0);
        rd(3'd3, v);
        check("R6 hardware start", v, 16'h002D);
        check("R9 flag set", W'(flag), 16'd1);
        rd(3'd5, v);
        check("R7 no reload on start", v, 16'h00AB);
        cyc(2);
        rd(3'd5, v);
        check("R7 first increment", v, 16'h00AC);

        wr(3'd6, 16'h0000);
        check("R9 flag cleared", W'(flag), 16'd0);

        wait_trig(t2);
        check("R3 update period", W'(t2 - t1), 16'd18);
        cyc(1);
        check("R11 flag set again", W'(flag), 16'd1);
        rd(3'd3, v);
        check("R11 still running", v, 16'h002D);
        rd(3'd5, v);
        check("R11 count undisturbed", v, 16'h00B1);

        wr(3'd3, 16'h002C);
        rd(3'd5, v);
        check("R8 stop count", v, 16'h00B2);
        cyc(9);
        rd(3'd5, v);
        check("R8 held while stopped", v, 16'h00B2);
        rd(3'd3, v);
        check("R8 enable clear", v, 16'h002C);

        wait_trig(t1);
        cyc(1);
        rd(3'd3, v);
        check("R6 restart", v, 16'h002D);
        rd(3'd5, v);
        check("R7 resume non-zero", v, 16'h00B2);

        // outside trigger mode
        wr(3'd3, 16'h0020);
        wr(3'd6, 16'h0000);
        rd(3'd5, n[W-1:0]);
        cyc(40);
        rd(3'd3, v);
        check("R12 no start", v, 16'h0020);
        check("R12 no flag", W'(flag), 16'd0);
        rd(3'd5, v);
        check("R12 count held", v, n[W-1:0]);

        // wrong trigger source
        wr(3'd3, 16'h003C);
        cyc(40);
        rd(3'd3, v);
        check("R5 source mismatch no start", v, 16'h003C);
        check("R5 source mismatch no flag", W'(flag), 16'd0);

        // output-select decoding
        wr(3'd0, 16'h0001);
        highs = 0;
        for (int k = 0; k < 40; k++) begin
            cyc(1);
            if (trig_out) highs++;
        end
        check("R4 select none", W'(highs), 16'd0);
        wr(3'd0, 16'h0003);
        check("R4 select run high", W'(trig_out), 16'd1);
        wr(3'd0, 16'h0002);
        check("R4 select run low", W'(trig_out), 16'd0);

        // counter writes
        wr(3'd0, 16'h0005);
        wr(3'd2, 16'h0003);
        rd(3'd2, v);
        check("R10 master count write", v, 16'h0003);
        wr(3'd5, 16'h1234);
        rd(3'd5, v);
        check("R10 slave count write", v, 16'h1234);

        // reset in the middle of a run
        @(negedge clk);
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
        reset_checks("R1 reset mid-run");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule